// File: doc/BRIEF.md
# Multiplexed Receive Silo with Interrupt Timeout

This block gathers received characters and modem events from sixteen serial lines into a single shared queue, called the silo. The host drains the queue one word at a time. Each word carries the byte, the number of the line it came from, and error flags. Status entries use the same queue. A status entry reports either a carrier-detect change on a line or a diagnostic code produced by a self-test.

The host programs an 8-bit timeout value that decides when the receive interrupt is raised:

- **Value 1:** the interrupt is raised as soon as anything is queued.
- **Value 0:** the interrupt is raised only by a modem-status entry or by the three-quarter-full alarm.
- **Values 2 to 255:** the block counts that many millisecond ticks after the first entry lands in an empty silo, then raises the interrupt.

The alarm and modem-status conditions raise the interrupt in every mode.

Each line presents a request and holds it until the block returns a one-cycle take for that line. The block writes at most one entry per clock. The host reads by pulsing a read strobe, which pops the head entry. While the top bit of the read word is set, the word is a valid entry and the host keeps reading.

Top module: `rx_silo`

## Requirements
- R1: `rd_word[15]` is 1 exactly when the silo holds at least one entry, and then bits 14:0 show the oldest entry. When the silo is empty, `rd_word` is all zeros.
- R2: A character entry has the following layout:
  - bits 7:0: the byte.
  - bits 11:8: the source line number.
  - bit 12: parity error.
  - bit 13: framing error.
  - bit 14: overrun.
- R3: Flag code 3'b111 (bits 14:12) marks a status entry.
  - A modem entry carries its line in bits 11:8, the carrier level in bit 0, and 0 in bits 7:1.
  - A diagnostic entry has line 0, bit 7 set, and its code in bits 2:0.
- R4: At most one take is issued per cycle. Priority order is: diagnostic loading first, then the lowest-numbered modem request, then the lowest-numbered character request.
- R5: A character entry never carries flag code 3'b111. If overrun and framing error would both be set together with parity error, the parity bit is written as 0.
- R6: A character taken while the silo holds DEPTH entries is dropped and is still acknowledged. The next character entry written then carries the overrun flag. Fullness is judged on the count stored before the cycle's read. Modem and diagnostic entries are also dropped when the silo is full, but they do not set the overrun flag.
- R7: With timeout value 1, the interrupt is active in every cycle that the silo is non-empty.
- R8: With timeout value 0, the interrupt is active only in these cases:
  - a modem entry has been written since the silo was last empty, or
  - the silo holds at least 3/4 of DEPTH entries.
- R9: With timeout value N ≥ 2, the interrupt rises on the clock edge that samples the N-th tick after the first entry entered an empty silo. A tick in the same cycle as that first write is not counted. Draining the silo to empty restarts the timer.
- R10: The interrupt output is low whenever the receive-interrupt enable `rie` is low.
- R11: A `selftest` pulse empties the silo and clears the overrun flag. It then writes exactly eight diagnostic entries, with codes 0 to 7, on the eight following cycles.
- R12: A read pops the head entry only when the silo is non-empty. A read of an empty silo changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| selftest | input | 1 | Flush the silo and load eight diagnostic entries |
| chr_req | input | 16 | Per-line character request, held until taken |
| chr_data | input | 128 | Per-line byte; line i uses bits 8i+7:8i |
| chr_pe | input | 16 | Per-line parity error |
| chr_fe | input | 16 | Per-line framing error |
| chr_take | output | 16 | Per-line character acknowledge |
| mdm_req | input | 16 | Per-line modem-change request, held until taken |
| mdm_dcd | input | 16 | Per-line carrier-detect level |
| mdm_take | output | 16 | Per-line modem acknowledge |
| tick_ms | input | 1 | One-cycle millisecond tick |
| timo | input | 8 | Timeout value (0, 1, or 2..255) |
| rie | input | 1 | Receive-interrupt enable |
| rd | input | 1 | Read strobe; pops the head entry |
| rd_word | output | 16 | Valid flag and head entry |
| irq | output | 1 | Receive interrupt |

## Verification
The bench drives several pairs of functions into the same cycle:
- a read strobe on the same edge as a write, both on a full silo and on an empty one;
- modem and character requests raised together, so arbitration and queueing overlap;
- ticks arriving while entries are being written.

A behavioural model predicts, for every clock, the head word, the interrupt level and the take vectors. Mismatches are reported against the requirement that the signal's current mode covers. The overrun case, where a dropped character and a later write must leave the right flag, is judged on the final drained word.

// File: rtl/rsilo_pkg.sv
package rsilo_pkg;
  localparam int LINES  = 16;
  localparam int LINE_W = 4;
  localparam logic [2:0] FLG_STAT = 3'b111;

  typedef struct packed {
    logic [2:0]        flg;   // {overrun, framing, parity} or status code
    logic [LINE_W-1:0] line;
    logic [7:0]        dat;
  } rs_entry_t;

  localparam int ENTRY_W = $bits(rs_entry_t);
endpackage

// File: rtl/rsilo_arb.sv
module rsilo_arb #(
  parameter int N  = 16,
  parameter int LW = 4
) (
  input  logic          hold,
  input  logic [N-1:0]  chr_req,
  input  logic [N-1:0]  mdm_req,
  output logic [N-1:0]  chr_take,
  output logic [N-1:0]  mdm_take,
  output logic          sel_mdm,
  output logic          sel_chr,
  output logic [LW-1:0] sel_line
);
  logic          mhit, chit;
  logic [LW-1:0] mline, cline;

  // lowest-numbered requester wins in each class
  always_comb begin
    mhit = 1'b0; chit = 1'b0;
    mline = '0;  cline = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (mdm_req[i]) begin mhit = 1'b1; mline = LW'(i); end
      if (chr_req[i]) begin chit = 1'b1; cline = LW'(i); end
    end
    sel_mdm  = ~hold & mhit;
    sel_chr  = ~hold & ~mhit & chit;
    sel_line = mhit ? mline : cline;
    chr_take = '0;
    mdm_take = '0;
    if (sel_mdm) mdm_take[mline] = 1'b1;
    if (sel_chr) chr_take[cline] = 1'b1;
  end
endmodule

// File: rtl/rsilo_fifo.sv
module rsilo_fifo #(
  parameter int DEPTH = 256,
  parameter int W     = 15,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic [AW:0]  cnt,
  output logic [AW:0]  cnt_nxt,
  output logic         full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr, wptr_nxt, rptr_nxt;

  always_comb begin
    wptr_nxt = wptr;
    rptr_nxt = rptr;
    cnt_nxt  = cnt;
    if (flush) begin
      wptr_nxt = '0; rptr_nxt = '0; cnt_nxt = '0;
    end else begin
      if (wr)  wptr_nxt = wptr + 1'b1;
      if (pop) rptr_nxt = rptr + 1'b1;
      cnt_nxt = cnt + (AW+1)'(wr) - (AW+1)'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; cnt <= '0;
    end else begin
      wptr <= wptr_nxt; rptr <= rptr_nxt; cnt <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (wr && !flush) mem[wptr] <= wdata;
  end

  assign head = mem[rptr];
  assign full = (cnt == (AW+1)'(DEPTH));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH));
  p_pop_one_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !wr && !flush) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/rsilo_irq.sv
module rsilo_irq #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int ALARM = (DEPTH * 3) / 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [AW:0] cnt,
  input  logic [AW:0] cnt_nxt,
  input  logic        wr,
  input  logic        wr_mdm,
  input  logic        tick,
  input  logic [7:0]  timo,
  input  logic        rie,
  output logic        irq
);
  logic       run, run_n, expd, expd_n, sseen, sseen_n;
  logic [7:0] tc, tc_n;
  logic       raw;

  always_comb begin
    run_n = run; expd_n = expd; sseen_n = sseen; tc_n = tc;
    if (cnt_nxt == '0) begin
      run_n = 1'b0; expd_n = 1'b0; sseen_n = 1'b0; tc_n = '0;
    end else begin
      if (cnt == '0 && wr) begin
        run_n = 1'b1; expd_n = 1'b0; tc_n = '0;
      end else if (run && tick && !expd) begin
        tc_n = tc + 1'b1;
        if ({1'b0, tc} + 9'd1 >= {1'b0, timo}) expd_n = 1'b1;
      end
      if (wr && wr_mdm) sseen_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; expd <= 1'b0; sseen <= 1'b0; tc <= '0;
    end else begin
      run <= run_n; expd <= expd_n; sseen <= sseen_n; tc <= tc_n;
    end
  end

  assign raw = ((cnt != '0) && (timo == 8'd1)) || sseen ||
               (cnt >= (AW+1)'(ALARM)) || (expd && (timo >= 8'd2));
  assign irq = rie & raw;

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> !raw);
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt) == '0 && cnt != '0) |-> (tc == '0 && !expd));
endmodule

// File: rtl/rx_silo.sv
module rx_silo
  import rsilo_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int NDIAG  = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int DGW   = $clog2(NDIAG) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 selftest,
  input  logic [LINES-1:0]     chr_req,
  input  logic [LINES*8-1:0]   chr_data,
  input  logic [LINES-1:0]     chr_pe,
  input  logic [LINES-1:0]     chr_fe,
  output logic [LINES-1:0]     chr_take,
  input  logic [LINES-1:0]     mdm_req,
  input  logic [LINES-1:0]     mdm_dcd,
  output logic [LINES-1:0]     mdm_take,
  input  logic                 tick_ms,
  input  logic [7:0]           timo,
  input  logic                 rie,
  input  logic                 rd,
  output logic [ENTRY_W:0]     rd_word,
  output logic                 irq
);
  logic [1:0]      rsq;
  logic            srst_n;
  logic [DGW-1:0]  dg_left, dg_left_n;
  logic [DGW-2:0]  dg_idx, dg_idx_n;
  logic            ovr, ovr_n;
  logic            dg_busy, sel_mdm, sel_chr, want, wr_acc, pop, chr_drop, full;
  logic [LINE_W-1:0] sel_line;
  rs_entry_t       went, head;
  logic [AW:0]     cnt, cnt_nxt;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsq <= 2'b00;
    else        rsq <= {rsq[0], 1'b1};
  end
  assign srst_n = rsq[1];

  assign dg_busy = (dg_left != '0);

  rsilo_arb #(.N(LINES), .LW(LINE_W)) u_arb (
    .hold(selftest | dg_busy), .chr_req(chr_req), .mdm_req(mdm_req),
    .chr_take(chr_take), .mdm_take(mdm_take),
    .sel_mdm(sel_mdm), .sel_chr(sel_chr), .sel_line(sel_line));

  always_comb begin
    went = '0;
    if (dg_busy) begin
      went.flg = FLG_STAT;
      went.dat = {1'b1, 4'b0, 3'(dg_idx)};
    end else if (sel_mdm) begin
      went.flg  = FLG_STAT;
      went.line = sel_line;
      went.dat  = {7'b0, mdm_dcd[sel_line]};
    end else begin
      went.flg  = {ovr, chr_fe[sel_line], chr_pe[sel_line] & ~(ovr & chr_fe[sel_line])};
      went.line = sel_line;
      went.dat  = chr_data[sel_line*8 +: 8];
    end
  end

  assign want     = ~selftest & (dg_busy | sel_mdm | sel_chr);
  assign wr_acc   = want & ~full;
  assign chr_drop = sel_chr & full;
  assign pop      = rd & (cnt != '0) & ~selftest;

  always_comb begin
    dg_left_n = dg_left;
    dg_idx_n  = dg_idx;
    ovr_n     = ovr;
    if (selftest) begin
      dg_left_n = DGW'(NDIAG);
      dg_idx_n  = '0;
      ovr_n     = 1'b0;
    end else begin
      if (dg_busy) begin
        dg_left_n = dg_left - 1'b1;
        dg_idx_n  = dg_idx + 1'b1;
      end
      if (chr_drop)              ovr_n = 1'b1;
      else if (sel_chr && wr_acc) ovr_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      dg_left <= '0; dg_idx <= '0; ovr <= 1'b0;
    end else begin
      dg_left <= dg_left_n; dg_idx <= dg_idx_n; ovr <= ovr_n;
    end
  end

  rsilo_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk(clk), .rst_n(srst_n), .flush(selftest), .wr(wr_acc), .wdata(went),
    .pop(pop), .head(head), .cnt(cnt), .cnt_nxt(cnt_nxt), .full(full));

  rsilo_irq #(.DEPTH(DEPTH)) u_irq (
    .clk(clk), .rst_n(srst_n), .cnt(cnt), .cnt_nxt(cnt_nxt),
    .wr(wr_acc), .wr_mdm(sel_mdm & ~dg_busy), .tick(tick_ms),
    .timo(timo), .rie(rie), .irq(irq));

  assign rd_word = (cnt != '0) ? {1'b1, head} : '0;

  p_prio_mdm_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (|mdm_req && !selftest && !dg_busy) |-> (chr_take == '0 && $countones(mdm_take) == 1));
  p_no_stat_code_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_acc && sel_chr) |-> (went.flg != FLG_STAT));
  p_drop_marks_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (|chr_take && full && !selftest) |=> ovr);
  p_gate_r10: assert property (@(posedge clk) disable iff (!srst_n)
    !rie |-> !irq);
  p_diag_first_r11: assert property (@(posedge clk) disable iff (!srst_n)
    $past(selftest) && !selftest |-> (chr_take == '0 && mdm_take == '0));
endmodule

// File: tb/sim_rx_silo.sv
`timescale 1ns/1ps
module sim_rx_silo;
  localparam int DEPTH = 256;
  localparam int ALARM = DEPTH * 3 / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic selftest = 1'b0, tick = 1'b0, rie = 1'b0, rd = 1'b0;
  logic [7:0] timo = 8'd1;
  logic [15:0] crq = '0, mrq = '0, cpe = '0, cfe = '0, mdcd = '0;
  logic [7:0]  cdat [16];
  logic [127:0] chr_data;
  logic [15:0] chr_take, mdm_take;
  logic [15:0] rd_word;
  logic irq;
  int n_run = 0, n_fail = 0, cyc = 0;
  logic live = 1'b0;

  always #4 clk = ~clk;

  always_comb for (int i = 0; i < 16; i++) chr_data[i*8 +: 8] = cdat[i];

  rx_silo u0 (.clk(clk), .rst_n(rst_n), .selftest(selftest), .chr_req(crq),
    .chr_data(chr_data), .chr_pe(cpe), .chr_fe(cfe), .chr_take(chr_take),
    .mdm_req(mrq), .mdm_dcd(mdcd), .mdm_take(mdm_take), .tick_ms(tick),
    .timo(timo), .rie(rie), .rd(rd), .rd_word(rd_word), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [14:0] q [$];
  logic mov = 0, mrun = 0, mex = 0, mss = 0;
  int mtc = 0, mdl = 0, mdi = 0;

  always @(negedge clk) begin
    if (live) begin
      logic [15:0] ew, ec, em;
      logic [14:0] e;
      logic eirq, wr, drop, pop;
      int kind, ln, old;
      string itag;
      ew = (q.size() != 0) ? {1'b1, q[0]} : 16'h0;
      chk("R1/R2 head word", rd_word, ew);
      eirq = rie && (((q.size() != 0) && timo == 8'd1) || mss || q.size() >= ALARM ||
                     (mex && timo >= 8'd2));
      itag = !rie ? "R10" : (timo == 0) ? "R8" : (timo == 1) ? "R7" : "R9";
      chk(itag, irq, eirq);
      kind = 0; ln = 0; ec = '0; em = '0;
      if (!selftest) begin
        if (mdl > 0) kind = 1;
        else if (mrq != 0) begin
          for (int i = 15; i >= 0; i--) if (mrq[i]) ln = i;
          kind = 2; em[ln] = 1'b1;
        end else if (crq != 0) begin
          for (int i = 15; i >= 0; i--) if (crq[i]) ln = i;
          kind = 3; ec[ln] = 1'b1;
        end
      end
      chk("R4 takes", {chr_take, mdm_take}, {ec, em});
      old = q.size();
      if (selftest) begin
        q.delete(); mov = 0; mrun = 0; mex = 0; mss = 0; mtc = 0; mdl = 8; mdi = 0;
      end else begin
        case (kind)
          1: e = {3'b111, 4'h0, 1'b1, 4'b0, 3'(mdi)};
          2: e = {3'b111, 4'(ln), 7'b0, mdcd[ln]};
          3: e = {mov, cfe[ln], cpe[ln] & ~(mov & cfe[ln]), 4'(ln), cdat[ln]};
          default: e = '0;
        endcase
        wr = (kind != 0) && (old < DEPTH);
        drop = (kind == 3) && (old >= DEPTH);
        pop = rd && (old > 0);
        if (pop) void'(q.pop_front());
        if (wr) q.push_back(e);
        if (kind == 1) begin mdl--; mdi++; end
        if (drop) mov = 1; else if (kind == 3 && wr) mov = 0;
        if (q.size() == 0) begin
          mrun = 0; mex = 0; mss = 0; mtc = 0;
        end else begin
          if (old == 0 && wr) begin mrun = 1; mtc = 0; mex = 0; end
          else if (mrun && tick && !mex) begin mtc++; if (mtc >= timo) mex = 1; end
          if (wr && kind == 2) mss = 1;
        end
      end
    end
  end

  // ---------------- stimulus helpers (entered at posedge+1) ----------------
  task automatic step(); @(posedge clk); #1; endtask

  task automatic post(input logic [15:0] cm, input logic [15:0] mm);
    logic [15:0] tc, tm;
    crq = cm; mrq = mm;
    for (int k = 0; k < 64 && (crq != 0 || mrq != 0); k++) begin
      @(negedge clk); tc = chr_take; tm = mdm_take;
      step();
      crq = crq & ~tc; mrq = mrq & ~tm;
    end
  endtask

  task automatic send(input int ln, input logic [7:0] d, input logic pe, input logic fe);
    cdat[ln] = d; cpe[ln] = pe; cfe[ln] = fe;
    post(16'(1) << ln, '0);
    cpe[ln] = 1'b0; cfe[ln] = 1'b0;
  endtask

  task automatic rd1(output logic [15:0] w);
    rd = 1'b1; @(negedge clk); w = rd_word; step(); rd = 1'b0;
  endtask

  task automatic drain(output logic [15:0] last);
    logic [15:0] w;
    last = '0;
    for (int k = 0; k < DEPTH + 4; k++) begin
      @(negedge clk); if (!rd_word[15]) break;
      step(); rd1(w); last = w;
    end
    step();
  endtask

  task automatic pulse_tick(); tick = 1'b1; step(); tick = 1'b0; step(); endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail); $finish;
    end
  end

  initial begin
    logic [15:0] w;
    for (int i = 0; i < 16; i++) cdat[i] = 8'h00;
    repeat (3) @(posedge clk); #1; rst_n = 1'b1;
    repeat (4) step();
    @(negedge clk);
    chk("R1 reset word", rd_word, 16'h0);
    chk("R10 reset irq", irq, 1'b0);
    step(); live = 1'b1;

    // immediate mode, single character with parity error
    rie = 1'b1; timo = 8'd1;
    send(3, 8'hA5, 1'b1, 1'b0);
    @(negedge clk); chk("R7 irq on char", irq, 1'b1); step();
    rd1(w); chk("R2 char layout", w, 16'h93A5);
    @(negedge clk); chk("R7 irq clears when empty", irq, 1'b0); step();

    // read of empty silo
    rd1(w); chk("R12 empty read", w, 16'h0);
    send(6, 8'h11, 1'b0, 1'b1);
    rd1(w); chk("R12 pointers intact", w, 16'hA611);

    // self-test diagnostics
    selftest = 1'b1; step(); selftest = 1'b0;
    repeat (10) step();
    for (int k = 0; k < 8; k++) begin
      rd1(w); chk("R11 diag entry", w, 16'hF080 | 16'(k));
    end
    @(negedge clk); chk("R11 exactly eight", rd_word[15], 1'b0); step();

    // alarm-only mode, modem entry raises
    timo = 8'd0;
    send(2, 8'h40, 1'b0, 1'b0);
    @(negedge clk); chk("R8 char alone quiet", irq, 1'b0); step();
    mdcd[9] = 1'b1; post('0, 16'h0200);
    @(negedge clk); chk("R8 modem raises", irq, 1'b1); step();
    rd1(w); rd1(w); chk("R3 modem entry", w, 16'hF901);

    // arbitration: modem and two characters at once, read during writes
    cdat[2] = 8'h22; cdat[7] = 8'h77; mdcd[4] = 1'b0;
    post(16'h0084, 16'h0010);
    rd1(w); chk("R4 modem first", w, 16'hF400);
    rd1(w); chk("R4 low line next", w, 16'h8222);
    rd1(w); chk("R4 high line last", w, 16'h8777);
    step();

    // fill to alarm, full, overflow
    for (int k = 0; k < ALARM - 1; k++) send(k % 16, 8'(k), 1'b0, 1'b0);
    @(negedge clk); chk("R8 below alarm", irq, 1'b0); step();
    send(0, 8'hEE, 1'b0, 1'b0);
    @(negedge clk); chk("R8 at alarm", irq, 1'b1); step();
    for (int k = ALARM; k < DEPTH + 2; k++) send(k % 16, 8'(k), 1'b0, 1'b0);
    rd1(w);
    // pop and write on the same edge while full is covered by the model
    send(1, 8'h33, 1'b1, 1'b1);
    drain(w); chk("R5 R6 overrun marked", w, 16'hE133);

    // timeout mode
    timo = 8'd5;
    send(8, 8'h08, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) pulse_tick();
    @(negedge clk); chk("R9 before timeout", irq, 1'b0); step();
    pulse_tick();
    @(negedge clk); chk("R9 at timeout", irq, 1'b1); step();
    drain(w);
    send(9, 8'h09, 1'b0, 1'b0);
    pulse_tick();
    @(negedge clk); chk("R9 restarted", irq, 1'b0); step();
    rie = 1'b0;
    for (int k = 0; k < 5; k++) pulse_tick();
    @(negedge clk); chk("R10 gated", irq, 1'b0); step();
    rie = 1'b1;
    @(negedge clk); chk("R9 expired visible", irq, 1'b1); step();
    drain(w);

    repeat (4) step();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule